// File: doc/BRIEF.md
# Mixing-Process Instruction Sequencer

This block is the control core of a small process-control machine used to configure and run mixing profiles. It pulls 16-bit instruction words from a synchronous program ROM, holds the current word in an instruction register and walks a short, opcode-specific chain of states. While it does so it emits one-cycle strobes to the surrounding units: the flag store (profile membership), the pointer register, the speed store, the peripheral activator, the threshold register and the mean-scan engine.

Each word carries a 4-bit opcode in bits 15:12 and a 12-bit operand in bits 11:0. The operand is presented on `opnd` for the whole execute phase, so every downstream unit takes its data from the same bus. Any opcode with bit 15 clear restarts the machine. Opcode 1111 blocks for a number of clocks counted by an internal down-counter. Opcode 1110 branches on the comparison flag returned by the external arithmetic unit.

Top module: `mix_seq`

## Requirements
- R1: While `rst_n` is low, `clr` is 1, `rom_rd`, `busy` and every strobe are 0. The first fetch after release happens two cycles after the release cycle, at address 0.
- R2: Every fetch is a single-cycle `rom_rd` with `rom_addr` equal to the program counter. Each executed non-jump instruction advances the counter by exactly one word.
- R3: Opcode 1000 (bits 15:12) raises `flag_wr` for one cycle, 3 cycles after its fetch, with the operand on `opnd`. The next fetch follows 6 cycles after its own.
- R4: Opcode 1001 raises `ptr_load` for one cycle, 3 cycles after its fetch. The next fetch comes 5 cycles after its own.
- R5: Opcode 1010 raises `spd_wr` for one cycle, 3 cycles after its fetch, carrying the 12-bit value on `opnd`. The next fetch comes 6 cycles after its own.
- R6: Opcode 1011 raises `act_strobe` for one cycle, 3 cycles after its fetch. The next fetch comes 5 cycles after its own.
- R7: Opcode 1100 raises `mean_start` 3 cycles after its fetch and holds `busy` from then until the cycle of `mean_load`. During that time there is no fetch. `mean_done` counts only from the cycle after `mean_start`. One cycle after `mean_done` is seen, `mean_load` pulses, and the next fetch follows one cycle later.
- R8: Opcode 1101 raises `thr_load` for one cycle, 3 cycles after its fetch. The next fetch comes 4 cycles after its own.
- R9: Opcode 1110 samples `cmp_flag` 3 cycles after its fetch. If the flag is 1, the next fetch is at the operand address; if 0, it is at the next word. In both cases the next fetch comes 4 cycles after its own.
- R10: Opcode 1111 with operand N places the next fetch N+5 cycles after its own.
- R11: Any word with bit 15 clear pulses `clr` 3 cycles after its fetch and raises no strobe. The next fetch is at address 0, 5 cycles after its own.
- R12: At most one of `flag_wr`, `ptr_load`, `spd_wr`, `act_strobe`, `thr_load`, `mean_start`, `mean_load` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rom_rd | output | 1 | Program ROM read enable |
| rom_addr | output | 12 | Program ROM word address (program counter) |
| rom_data | input | 16 | ROM read data, valid the cycle after `rom_rd` |
| opnd | output | 12 | Operand field of the current instruction |
| clr | output | 1 | Clear for buffers and mean registers |
| flag_wr | output | 1 | Flag store write strobe |
| ptr_load | output | 1 | Pointer register load |
| spd_wr | output | 1 | Speed store write strobe at the pointed location |
| act_strobe | output | 1 | Peripheral activation for the profile on `opnd` |
| thr_load | output | 1 | Threshold register load |
| mean_start | output | 1 | Starts a mean scan |
| mean_load | output | 1 | Mean register load |
| busy | output | 1 | A mean scan is in progress |
| mean_done | input | 1 | Mean scan finished |
| cmp_flag | input | 1 | Comparison result from the arithmetic unit |

## Verification
The risky overlap is a mean-scan completion that arrives in the very cycle the scan is launched, the same cycle `mean_start` is high. A sequencer that listens too early would close the scan before it ran. The bench raises `mean_done` exactly in the `mean_start` cycle and drops it one cycle later. It then expects `busy` to stay high, `mean_load` to stay low and no fetch to occur. Only a later, real completion may produce `mean_load` and the fetch of the next word on the cycles R7 gives.

// File: rtl/mix_seq.sv
module mix_seq #(
  parameter  int OW = 12,
  localparam int WW = OW + 4
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          rom_rd,
  output logic [OW-1:0] rom_addr,
  input  logic [WW-1:0] rom_data,
  output logic [OW-1:0] opnd,
  output logic          clr,
  output logic          flag_wr,
  output logic          ptr_load,
  output logic          spd_wr,
  output logic          act_strobe,
  output logic          thr_load,
  output logic          mean_start,
  output logic          mean_load,
  output logic          busy,
  input  logic          mean_done,
  input  logic          cmp_flag
);

  localparam logic [OW-1:0] ONE = {{(OW-1){1'b0}}, 1'b1};

  typedef enum logic [4:0] {
    S_INIT, S_IDLE, S_F1, S_F2, S_DEC,
    S_ADD1, S_ADD2, S_ADD3,
    S_PNT1, S_PNT2,
    S_SET1, S_SET2, S_SET3,
    S_RUN1, S_RUN2,
    S_FM1, S_FM2, S_FM3,
    S_CMP, S_JIC,
    S_WT1, S_WT2
  } state_t;

  state_t        st, nxt;
  logic [OW-1:0] pc, tmr;
  logic [WW-1:0] ir;
  logic [3:0]    op;
  logic          pc_inc, jmp;

  assign op = ir[WW-1 -: 4];

  always_comb begin
    nxt = st;
    case (st)
      S_INIT: nxt = S_IDLE;
      S_IDLE: nxt = S_F1;
      S_F1:   nxt = S_F2;
      S_F2:   nxt = S_DEC;
      S_DEC: begin
        if (!op[3]) nxt = S_INIT;
        else begin
          case (op[2:0])
            3'd0:    nxt = S_ADD1;
            3'd1:    nxt = S_PNT1;
            3'd2:    nxt = S_SET1;
            3'd3:    nxt = S_RUN1;
            3'd4:    nxt = S_FM1;
            3'd5:    nxt = S_CMP;
            3'd6:    nxt = S_JIC;
            default: nxt = S_WT1;
          endcase
        end
      end
      S_ADD1: nxt = S_ADD2;
      S_ADD2: nxt = S_ADD3;
      S_ADD3: nxt = S_F1;
      S_PNT1: nxt = S_PNT2;
      S_PNT2: nxt = S_F1;
      S_SET1: nxt = S_SET2;
      S_SET2: nxt = S_SET3;
      S_SET3: nxt = S_F1;
      S_RUN1: nxt = S_RUN2;
      S_RUN2: nxt = S_F1;
      S_FM1:  nxt = S_FM2;
      S_FM2:  if (mean_done) nxt = S_FM3;
      S_FM3:  nxt = S_F1;
      S_CMP:  nxt = S_F1;
      S_JIC:  nxt = S_F1;
      S_WT1:  nxt = S_WT2;
      S_WT2:  if (tmr == '0) nxt = S_F1;
      default: nxt = S_INIT;
    endcase
  end

  assign jmp    = (st == S_JIC) && cmp_flag;
  assign pc_inc = (st == S_ADD2) || (st == S_PNT1) || (st == S_SET1) ||
                  (st == S_RUN1) || (st == S_FM1)  || (st == S_CMP)  ||
                  (st == S_WT1)  || ((st == S_JIC) && !cmp_flag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_INIT;
      pc  <= '0;
      ir  <= '0;
      tmr <= '0;
    end else begin
      st <= nxt;
      if (st == S_INIT) begin
        pc  <= '0;
        ir  <= '0;
        tmr <= '0;
      end else begin
        if (jmp)         pc <= ir[OW-1:0];
        else if (pc_inc) pc <= pc + ONE;
        if (st == S_F2) ir <= rom_data;
        if (st == S_WT1)                    tmr <= ir[OW-1:0];
        else if (st == S_WT2 && tmr != '0)  tmr <= tmr - ONE;
      end
    end
  end

  assign rom_rd     = (st == S_F1);
  assign rom_addr   = pc;
  assign opnd       = ir[OW-1:0];
  assign clr        = (st == S_INIT);
  assign flag_wr    = (st == S_ADD1);
  assign ptr_load   = (st == S_PNT1);
  assign spd_wr     = (st == S_SET1);
  assign act_strobe = (st == S_RUN1);
  assign thr_load   = (st == S_CMP);
  assign mean_start = (st == S_FM1);
  assign mean_load  = (st == S_FM3);
  assign busy       = (st == S_FM1) || (st == S_FM2) || (st == S_FM3);

endmodule

// File: rtl/mix_seq_chk.sv
module mix_seq_chk #(
  parameter int OW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rom_rd,
  input logic [OW-1:0] rom_addr,
  input logic          clr,
  input logic          flag_wr,
  input logic          ptr_load,
  input logic          spd_wr,
  input logic          act_strobe,
  input logic          thr_load,
  input logic          mean_start,
  input logic          mean_load,
  input logic          busy
);

  a_r12_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flag_wr, ptr_load, spd_wr, act_strobe, thr_load, mean_start, mean_load}));

  a_r2_fetch_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd |=> !rom_rd);

  a_r7_start_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mean_start |-> busy);

  a_r7_no_fetch_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rom_rd);

  a_r7_load_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    mean_load |=> rom_rd);

  a_r8_thr_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    thr_load |=> rom_rd);

  a_r11_clear_restarts_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rom_addr == '0));

endmodule

bind mix_seq mix_seq_chk #(.OW(OW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rom_rd(rom_rd), .rom_addr(rom_addr), .clr(clr),
  .flag_wr(flag_wr), .ptr_load(ptr_load), .spd_wr(spd_wr), .act_strobe(act_strobe),
  .thr_load(thr_load), .mean_start(mean_start), .mean_load(mean_load), .busy(busy)
);

// File: tb/mix_seq_tb_top.sv
module mix_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rom_rd, clr, flag_wr, ptr_load, spd_wr, act_strobe, thr_load;
  logic mean_start, mean_load, busy;
  logic mean_done = 1'b0;
  logic cmp_flag = 1'b0;
  logic [11:0] rom_addr, opnd;
  logic [15:0] rom_q;
  logic [15:0] rom [16];

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (rom_rd) rom_q <= rom[rom_addr[3:0]];

  mix_seq dut_i (
    .clk(clk), .rst_n(rst_n), .rom_rd(rom_rd), .rom_addr(rom_addr), .rom_data(rom_q),
    .opnd(opnd), .clr(clr), .flag_wr(flag_wr), .ptr_load(ptr_load), .spd_wr(spd_wr),
    .act_strobe(act_strobe), .thr_load(thr_load), .mean_start(mean_start),
    .mean_load(mean_load), .busy(busy), .mean_done(mean_done), .cmp_flag(cmp_flag)
  );

  localparam int I_FLG = 0, I_PTR = 1, I_SPD = 2, I_ACT = 3, I_MST = 4, I_MLD = 5, I_THR = 6;
  logic [6:0] stb;
  assign stb = {thr_load, mean_load, mean_start, act_strobe, spd_wr, ptr_load, flag_wr};
  int sc [7] = '{default: 0};
  int stt [7] = '{default: -1};
  logic [11:0] so [7];
  int overlap = 0;
  int clr_t = -1;

  always @(negedge clk) if (rst_n) begin
    if ($countones(stb) > 1) overlap++;
    if (clr) clr_t = cyc;
    for (int i = 0; i < 7; i++) if (stb[i]) begin
      sc[i]++;
      stt[i] = cyc;
      so[i] = opnd;
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_fetch(output int t, output int a);
    t = -1;
    a = -1;
    for (int i = 0; i < 64; i++) begin
      tick();
      if (rom_rd) begin
        t = cyc;
        a = int'(rom_addr);
        return;
      end
    end
  endtask

  task automatic load_clear();
    for (int i = 0; i < 16; i++) rom[i] = 16'h0000;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    int t, a, c;
    load_clear();
    rst_n = 1'b0;
    tick(); tick(); tick();
    chk("R1 clr in reset", int'(clr), 1);
    chk("R1 strobes in reset", int'(stb), 0);
    chk("R1 rom_rd/busy in reset", int'({rom_rd, busy}), 0);
    rst_n = 1'b1;
    c = cyc;
    wait_fetch(t, a);
    chk("R1 first fetch addr", a, 0);
    chk("R1 first fetch cycle", t, c + 2);
  endtask

  task automatic t_config();
    int t0, t1, t2, t3, t4, t5, t6, a, base;
    load_clear();
    rom[0] = 16'h8123;
    rom[1] = 16'h9045;
    rom[2] = 16'hA271;
    rom[3] = 16'hB001;
    rom[4] = 16'hD0C8;
    rom[5] = 16'h7ABC;
    do_reset();
    base = sc[0] + sc[1] + sc[2] + sc[3] + sc[4] + sc[5] + sc[6];
    wait_fetch(t0, a);
    wait_fetch(t1, a);
    chk("R2 addr after add", a, 1);
    chk("R3 add length", t1 - t0, 6);
    chk("R3 flag_wr cycle", stt[I_FLG], t0 + 3);
    chk("R3 flag_wr operand", int'(so[I_FLG]), 12'h123);
    wait_fetch(t2, a);
    chk("R2 addr after point", a, 2);
    chk("R4 point length", t2 - t1, 5);
    chk("R4 ptr_load cycle", stt[I_PTR], t1 + 3);
    chk("R4 ptr_load operand", int'(so[I_PTR]), 12'h045);
    wait_fetch(t3, a);
    chk("R2 addr after set", a, 3);
    chk("R5 set length", t3 - t2, 6);
    chk("R5 spd_wr cycle", stt[I_SPD], t2 + 3);
    chk("R5 spd_wr value", int'(so[I_SPD]), 12'h271);
    wait_fetch(t4, a);
    chk("R2 addr after run", a, 4);
    chk("R6 run length", t4 - t3, 5);
    chk("R6 act_strobe cycle", stt[I_ACT], t3 + 3);
    chk("R6 act profile", int'(so[I_ACT]), 1);
    wait_fetch(t5, a);
    chk("R2 addr after compare", a, 5);
    chk("R8 compare length", t5 - t4, 4);
    chk("R8 thr_load cycle", stt[I_THR], t4 + 3);
    chk("R8 threshold operand", int'(so[I_THR]), 12'h0C8);
    wait_fetch(t6, a);
    chk("R11 restart addr", a, 0);
    chk("R11 restart length", t6 - t5, 5);
    chk("R11 clr cycle", clr_t, t5 + 3);
    chk("R11 no extra strobe", sc[0] + sc[1] + sc[2] + sc[3] + sc[4] + sc[5] + sc[6] - base, 5);
  endtask

  task automatic t_jump();
    int t0, t1, t2, t3, a;
    load_clear();
    rom[0]  = 16'hD0C8;
    rom[1]  = 16'hE00A;
    rom[10] = 16'hE003;
    cmp_flag = 1'b1;
    do_reset();
    wait_fetch(t0, a);
    wait_fetch(t1, a);
    wait_fetch(t2, a);
    chk("R9 taken target", a, 10);
    chk("R9 taken length", t2 - t1, 4);
    cmp_flag = 1'b0;
    wait_fetch(t3, a);
    chk("R9 not taken next word", a, 11);
    chk("R9 not taken length", t3 - t2, 4);
  endtask

  task automatic t_wait();
    int t0, t1, t2, a;
    load_clear();
    rom[0] = 16'hF007;
    rom[1] = 16'hF000;
    do_reset();
    wait_fetch(t0, a);
    wait_fetch(t1, a);
    chk("R10 wait 7 length", t1 - t0, 12);
    chk("R10 addr after wait", a, 1);
    wait_fetch(t2, a);
    chk("R10 wait 0 length", t2 - t1, 5);
  endtask

  task automatic t_mean();
    int t0, a;
    load_clear();
    rom[0] = 16'hC100;
    mean_done = 1'b0;
    do_reset();
    wait_fetch(t0, a);
    tick(); tick(); tick();
    chk("R7 mean_start cycle", int'(mean_start), 1);
    chk("R7 busy at start", int'(busy), 1);
    mean_done = 1'b1;
    tick();
    mean_done = 1'b0;
    chk("R7 early done ignored busy", int'(busy), 1);
    chk("R7 early done no load", int'(mean_load), 0);
    tick(); tick(); tick(); tick();
    chk("R7 stall busy", int'(busy), 1);
    chk("R7 stall no fetch", int'(rom_rd), 0);
    mean_done = 1'b1;
    tick();
    mean_done = 1'b0;
    chk("R7 mean_load after done", int'(mean_load), 1);
    chk("R7 mean_load cycle", cyc, t0 + 9);
    tick();
    chk("R7 fetch after load", int'(rom_rd), 1);
    chk("R7 next addr", int'(rom_addr), 1);
    chk("R7 busy released", int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_config();
    t_jump();
    t_wait();
    t_mean();
    chk("R12 strobe overlap count", overlap, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule